// File: doc/BRIEF.md
# Packed SIMD Integer ALU

This block is an integer arithmetic unit that treats a 64-bit operand pair as a group of narrow, independent lanes. A two-bit size field splits the word into eight 8-bit lanes, four 16-bit lanes or two 32-bit lanes. A four-bit opcode picks one lane-parallel operation: wrapping or saturating add and subtract, logical and arithmetic shifts, bitwise logic, equality and greater-than compares that return lane masks, a four-lane 16-bit multiply, a multiply with pairwise accumulation, and a narrowing pack that clamps out-of-range values.

The unit sits in a media or signal datapath. Every rising clock edge samples the operands and controls and registers the result, so a new operation can be issued each cycle and its answer appears one edge later. Carries, borrows and shifted-out bits never cross a lane boundary.

Top module: `simd_lane_alu`

## Requirements
- R1: `result` is a register. Inputs sampled at a rising edge appear at `result` after that edge and not before it. A high `rst` at an edge clears `result` to zero.
- R2: `lane_sz` selects the lane width: 0 gives 8-bit, 1 gives 16-bit, 2 and 3 give 32-bit. With `sat_en`=0, add (opcode 0) and subtract (opcode 1, a minus b) wrap modulo the lane width, and no carry or borrow moves into a neighbouring lane.
- R3: With `sat_en`=1 and `is_signed`=0, an add that overflows gives all ones in that lane, and a subtract that underflows gives zero.
- R4: With `sat_en`=1 and `is_signed`=1, a signed overflow of add or subtract clamps the lane to the signed maximum or minimum, taking the side the true result lies on.
- R5: Opcode 2 shifts left, 3 shifts right logically and 4 shifts right arithmetically. Each lane of `op_a` is shifted by `shamt`. A count at or above the lane width gives zero for opcodes 2 and 3, and a copy of the lane's sign bit in every position for opcode 4.
- R6: Opcode 5 computes a AND b, 6 computes (NOT a) AND b, 7 computes a OR b and 8 computes a XOR b. Each is a bitwise operation over all 64 bits, whatever the lane size.
- R7: Opcode 9 (a equal to b) and opcode 10 (a greater than b, signed when `is_signed`=1, unsigned otherwise) set each lane to all ones when the test is true and to all zeros when it is false.
- R8: Opcode 11 multiplies four 16-bit lanes and keeps the low 16 bits of each product. `lane_sz` has no effect.
- R9: Opcode 12 forms four 16-bit products, signed when `is_signed`=1 and unsigned otherwise. It adds products 0 and 1 into bits 31:0 and products 2 and 3 into bits 63:32, each sum taken modulo 2^32.
- R10: Opcode 13 packs. `lane_sz`=1 narrows 16-bit lanes to 8 bits, and `lane_sz` 2 or 3 narrows 32-bit lanes to 16 bits. Lanes from `op_a` fill the low 32 bits and lanes from `op_b` fill the high 32 bits, with lane order kept. With `is_signed`=1 a value outside the signed destination range clamps to its maximum or minimum. With `is_signed`=0 the source is read as unsigned and clamps to the unsigned destination maximum. `lane_sz`=0 gives zero.
- R11: Opcodes 14 and 15 give a zero result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| op_a | input | 64 | First operand |
| op_b | input | 64 | Second operand |
| opcode | input | 4 | Operation select |
| lane_sz | input | 2 | Lane width select |
| is_signed | input | 1 | Signed interpretation for saturation, compare, multiply-add and pack |
| sat_en | input | 1 | Saturate add and subtract instead of wrapping |
| shamt | input | 7 | Shift count |
| result | output | 64 | Registered lane-wise result |

## Verification
The assertions watch properties that hold for any operands on every cycle. The reset value must be zero. A compare must produce whole-byte masks. A value XORed with itself or subtracted from itself must give zero. A left shift by 32 or more must clear the word. An unsigned saturating subtract from zero must stay at zero, and a multiply by zero must give zero. Exact lane values cannot be shown that way. These include carries held at lane boundaries, saturation limits on each side, sign fill from large arithmetic shifts, pairwise multiply-add sums, and the position and clamping of packed lanes. Only the bench's directed corner cases and its seeded random operations, compared against an independent lane model, can show them.

// File: rtl/simd_pkg.sv
package simd_pkg;

  typedef enum logic [3:0] {
    OP_ADD   = 4'd0,
    OP_SUB   = 4'd1,
    OP_SLL   = 4'd2,
    OP_SRL   = 4'd3,
    OP_SRA   = 4'd4,
    OP_AND   = 4'd5,
    OP_ANDN  = 4'd6,
    OP_OR    = 4'd7,
    OP_XOR   = 4'd8,
    OP_CMPEQ = 4'd9,
    OP_CMPGT = 4'd10,
    OP_MUL   = 4'd11,
    OP_MADD  = 4'd12,
    OP_PACK  = 4'd13
  } simd_op_e;

  typedef enum logic [1:0] {
    SHM_LEFT  = 2'd0,
    SHM_RIGHT = 2'd1,
    SHM_ARITH = 2'd2
  } shift_mode_e;

endpackage

// File: rtl/simd_addsub.sv
module simd_addsub #(
  parameter int DATA_W = 64,
  parameter int BASE_W = 8,
  parameter int NUM_SZ = 3
) (
  input  logic [DATA_W-1:0]              a,
  input  logic [DATA_W-1:0]              b,
  input  logic                           sub,
  input  logic                           is_signed,
  input  logic                           sat_en,
  output logic [NUM_SZ-1:0][DATA_W-1:0]  res_by_sz
);

  for (genvar g = 0; g < NUM_SZ; g++) begin : g_sz
    localparam int LW = BASE_W << g;
    localparam int NL = DATA_W / LW;
    for (genvar l = 0; l < NL; l++) begin : g_ln
      logic [LW-1:0] x, y, s, r;
      logic          cy, ovf;
      assign x = a[l*LW +: LW];
      assign y = b[l*LW +: LW];
      // carry or borrow stays in the lane
      assign {cy, s} = sub ? ({1'b0, x} - {1'b0, y}) : ({1'b0, x} + {1'b0, y});
      assign ovf = sub ? ((x[LW-1] != y[LW-1]) && (s[LW-1] != x[LW-1]))
                       : ((x[LW-1] == y[LW-1]) && (s[LW-1] != x[LW-1]));
      always_comb begin
        if (!sat_en) begin
          r = s;
        end else if (is_signed) begin
          if (ovf) r = x[LW-1] ? {1'b1, {(LW-1){1'b0}}} : {1'b0, {(LW-1){1'b1}}};
          else     r = s;
        end else begin
          if (cy) r = sub ? '0 : '1;
          else    r = s;
        end
      end
      assign res_by_sz[g][l*LW +: LW] = r;
    end
  end

endmodule

// File: rtl/simd_shift.sv
module simd_shift
  import simd_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int BASE_W = 8,
  parameter int NUM_SZ = 3,
  parameter int SH_W   = 7
) (
  input  logic [DATA_W-1:0]              a,
  input  logic [SH_W-1:0]                shamt,
  input  shift_mode_e                    mode,
  output logic [NUM_SZ-1:0][DATA_W-1:0]  res_by_sz
);

  for (genvar g = 0; g < NUM_SZ; g++) begin : g_sz
    localparam int LW = BASE_W << g;
    localparam int NL = DATA_W / LW;
    for (genvar l = 0; l < NL; l++) begin : g_ln
      logic [LW-1:0] x, r;
      logic          big;
      assign x   = a[l*LW +: LW];
      assign big = (shamt >= SH_W'(LW));
      always_comb begin
        case (mode)
          SHM_LEFT:  r = big ? '0 : (x << shamt);
          SHM_RIGHT: r = big ? '0 : (x >> shamt);
          SHM_ARITH: r = big ? {LW{x[LW-1]}} : $unsigned($signed(x) >>> shamt);
          default:   r = '0;
        endcase
      end
      assign res_by_sz[g][l*LW +: LW] = r;
    end
  end

endmodule

// File: rtl/simd_mul.sv
module simd_mul #(
  parameter int DATA_W = 64,
  parameter int MUL_W  = 16
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              is_signed,
  output logic [DATA_W-1:0] mul_res,
  output logic [DATA_W-1:0] madd_res
);

  localparam int NL = DATA_W / MUL_W;
  localparam int NP = NL / 2;
  localparam int PW = 2 * MUL_W;

  logic [NL-1:0][PW-1:0] prod;

  for (genvar l = 0; l < NL; l++) begin : g_ln
    logic signed [MUL_W:0] xe, ye;
    assign xe = {is_signed & a[l*MUL_W + MUL_W-1], a[l*MUL_W +: MUL_W]};
    assign ye = {is_signed & b[l*MUL_W + MUL_W-1], b[l*MUL_W +: MUL_W]};
    assign prod[l] = PW'(xe * ye);
    assign mul_res[l*MUL_W +: MUL_W] = prod[l][MUL_W-1:0];
  end

  for (genvar k = 0; k < NP; k++) begin : g_pair
    assign madd_res[k*PW +: PW] = prod[2*k] + prod[2*k+1];
  end

endmodule

// File: rtl/simd_pack.sv
module simd_pack #(
  parameter int DATA_W = 64,
  parameter int BASE_W = 8,
  parameter int NUM_SZ = 3
) (
  input  logic [DATA_W-1:0]              a,
  input  logic [DATA_W-1:0]              b,
  input  logic                           is_signed,
  output logic [NUM_SZ-1:0][DATA_W-1:0]  res_by_sz
);

  localparam int HALF = DATA_W / 2;

  assign res_by_sz[0] = '0;

  for (genvar g = 1; g < NUM_SZ; g++) begin : g_sz
    localparam int LW = BASE_W << g;
    localparam int DW = LW / 2;
    localparam int NL = DATA_W / LW;
    for (genvar o = 0; o < 2; o++) begin : g_src
      for (genvar l = 0; l < NL; l++) begin : g_ln
        logic [LW-1:0] src;
        logic [DW-1:0] r;
        logic          fits_s, fits_u;
        assign src    = (o == 0) ? a[l*LW +: LW] : b[l*LW +: LW];
        assign fits_s = (&src[LW-1:DW-1]) | ~(|src[LW-1:DW-1]);
        assign fits_u = ~(|src[LW-1:DW]);
        always_comb begin
          if (is_signed)
            r = fits_s ? src[DW-1:0]
                       : (src[LW-1] ? {1'b1, {(DW-1){1'b0}}} : {1'b0, {(DW-1){1'b1}}});
          else
            r = fits_u ? src[DW-1:0] : '1;
        end
        assign res_by_sz[g][o*HALF + l*DW +: DW] = r;
      end
    end
  end

endmodule

// File: rtl/simd_lane_alu.sv
module simd_lane_alu
  import simd_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int BASE_W = 8,
  parameter int NUM_SZ = 3,
  parameter int SH_W   = 7,
  parameter int MUL_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [63:0]       op_a,
  input  logic [63:0]       op_b,
  input  logic [3:0]        opcode,
  input  logic [1:0]        lane_sz,
  input  logic              is_signed,
  input  logic              sat_en,
  input  logic [6:0]        shamt,
  output logic [63:0]       result
);

  localparam int SZ_W = $clog2(NUM_SZ);
  localparam int NB   = DATA_W / BASE_W;
  localparam int MAXW = BASE_W << (NUM_SZ - 1);

  logic [SZ_W-1:0]                sz_idx;
  logic [NUM_SZ-1:0][DATA_W-1:0]  as_res, sh_res, pk_res, eq_res, gt_res;
  logic [DATA_W-1:0]              mul_res, madd_res, nxt;
  shift_mode_e                    sh_mode;
  simd_op_e                       op_e;

  assign op_e   = simd_op_e'(opcode);
  assign sz_idx = (lane_sz >= 2'(NUM_SZ)) ? SZ_W'(NUM_SZ - 1) : SZ_W'(lane_sz);

  always_comb begin
    case (op_e)
      OP_SRL:  sh_mode = SHM_RIGHT;
      OP_SRA:  sh_mode = SHM_ARITH;
      default: sh_mode = SHM_LEFT;
    endcase
  end

  simd_addsub #(.DATA_W(DATA_W), .BASE_W(BASE_W), .NUM_SZ(NUM_SZ)) addsub_i (
    .a(op_a), .b(op_b), .sub(op_e == OP_SUB), .is_signed(is_signed),
    .sat_en(sat_en), .res_by_sz(as_res)
  );

  simd_shift #(.DATA_W(DATA_W), .BASE_W(BASE_W), .NUM_SZ(NUM_SZ), .SH_W(SH_W)) shift_i (
    .a(op_a), .shamt(shamt), .mode(sh_mode), .res_by_sz(sh_res)
  );

  simd_mul #(.DATA_W(DATA_W), .MUL_W(MUL_W)) mul_i (
    .a(op_a), .b(op_b), .is_signed(is_signed), .mul_res(mul_res), .madd_res(madd_res)
  );

  simd_pack #(.DATA_W(DATA_W), .BASE_W(BASE_W), .NUM_SZ(NUM_SZ)) pack_i (
    .a(op_a), .b(op_b), .is_signed(is_signed), .res_by_sz(pk_res)
  );

  // lane compares produce whole-lane masks
  for (genvar g = 0; g < NUM_SZ; g++) begin : g_cmp
    localparam int LW = BASE_W << g;
    localparam int NL = DATA_W / LW;
    for (genvar l = 0; l < NL; l++) begin : g_ln
      logic [LW-1:0] x, y;
      logic          gt;
      assign x  = op_a[l*LW +: LW];
      assign y  = op_b[l*LW +: LW];
      assign gt = is_signed ? ($signed(x) > $signed(y)) : (x > y);
      assign eq_res[g][l*LW +: LW] = {LW{x == y}};
      assign gt_res[g][l*LW +: LW] = {LW{gt}};
    end
  end

  always_comb begin
    case (op_e)
      OP_ADD, OP_SUB:         nxt = as_res[sz_idx];
      OP_SLL, OP_SRL, OP_SRA: nxt = sh_res[sz_idx];
      OP_AND:                 nxt = op_a & op_b;
      OP_ANDN:                nxt = ~op_a & op_b;
      OP_OR:                  nxt = op_a | op_b;
      OP_XOR:                 nxt = op_a ^ op_b;
      OP_CMPEQ:               nxt = eq_res[sz_idx];
      OP_CMPGT:               nxt = gt_res[sz_idx];
      OP_MUL:                 nxt = mul_res;
      OP_MADD:                nxt = madd_res;
      OP_PACK:                nxt = pk_res[sz_idx];
      default:                nxt = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) result <= '0;
    else     result <= nxt;
  end

  // ---------------- assertions ----------------
  logic [NB-1:0] byte_is_mask;
  for (genvar i = 0; i < NB; i++) begin : g_bm
    assign byte_is_mask[i] = (result[i*BASE_W +: BASE_W] == '0) ||
                             (result[i*BASE_W +: BASE_W] == '1);
  end

  p_reset_clear_r1: assert property (@(posedge clk) rst |=> result == '0);

  p_sub_self_zero_r2: assert property (@(posedge clk) disable iff (rst)
    $past(opcode == OP_SUB && op_a == op_b) |-> result == '0);

  p_usat_floor_r3: assert property (@(posedge clk) disable iff (rst)
    $past(opcode == OP_SUB && sat_en && !is_signed && op_a == '0) |-> result == '0);

  p_sll_flush_r5: assert property (@(posedge clk) disable iff (rst)
    $past(opcode == OP_SLL && shamt >= SH_W'(MAXW)) |-> result == '0);

  p_xor_self_r6: assert property (@(posedge clk) disable iff (rst)
    $past(opcode == OP_XOR && op_a == op_b) |-> result == '0);

  p_cmp_mask_r7: assert property (@(posedge clk) disable iff (rst)
    $past(opcode == OP_CMPEQ || opcode == OP_CMPGT) |-> &byte_is_mask);

  p_mul_zero_r8: assert property (@(posedge clk) disable iff (rst)
    $past(opcode == OP_MUL && op_b == '0) |-> result == '0);

endmodule

// File: tb/simd_lane_alu_tb.sv
module simd_lane_alu_tb_top;

  localparam real CLK_NS = 4.0;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] op_a = '0, op_b = '0;
  logic [3:0]  opcode = '0;
  logic [1:0]  lane_sz = '0;
  logic        is_signed = 1'b0, sat_en = 1'b0;
  logic [6:0]  shamt = '0;
  logic [63:0] result;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #(CLK_NS/2) clk = ~clk;

  simd_lane_alu dut_i (
    .clk(clk), .rst(rst), .op_a(op_a), .op_b(op_b), .opcode(opcode),
    .lane_sz(lane_sz), .is_signed(is_signed), .sat_en(sat_en),
    .shamt(shamt), .result(result)
  );

  function automatic longint uval(logic [63:0] v, int pos, int w);
    return longint'((v >> pos) & ((64'd1 << w) - 64'd1));
  endfunction

  function automatic longint sval(logic [63:0] v, int pos, int w);
    longint u = uval(v, pos, w);
    return (u >= (longint'(1) << (w-1))) ? u - (longint'(1) << w) : u;
  endfunction

  function automatic logic [63:0] ref_model(logic [63:0] a, logic [63:0] b,
      int op, int sz, bit sg, bit sat, int sh);
    logic [63:0] res = '0;
    int     lw = (sz == 0) ? 8 : (sz == 1) ? 16 : 32;
    int     nl = 64 / lw;
    longint mask = (longint'(1) << lw) - 1;
    case (op)
      0, 1: for (int i = 0; i < nl; i++) begin
        longint r;
        if (sat && sg) begin
          longint lo = -(longint'(1) << (lw-1));
          longint hi = (longint'(1) << (lw-1)) - 1;
          r = (op == 0) ? sval(a, i*lw, lw) + sval(b, i*lw, lw)
                        : sval(a, i*lw, lw) - sval(b, i*lw, lw);
          if (r > hi) r = hi;
          if (r < lo) r = lo;
        end else begin
          r = (op == 0) ? uval(a, i*lw, lw) + uval(b, i*lw, lw)
                        : uval(a, i*lw, lw) - uval(b, i*lw, lw);
          if (sat && r > mask) r = mask;
          if (sat && r < 0) r = 0;
        end
        res |= 64'(r & mask) << (i*lw);
      end
      2, 3, 4: for (int i = 0; i < nl; i++) begin
        longint r;
        if (sh >= lw) r = (op == 4 && sval(a, i*lw, lw) < 0) ? mask : 0;
        else if (op == 2) r = uval(a, i*lw, lw) << sh;
        else if (op == 3) r = uval(a, i*lw, lw) >> sh;
        else r = sval(a, i*lw, lw) >>> sh;
        res |= 64'(r & mask) << (i*lw);
      end
      5: res = a & b;
      6: res = ~a & b;
      7: res = a | b;
      8: res = a ^ b;
      9, 10: for (int i = 0; i < nl; i++) begin
        bit t;
        if (op == 9) t = uval(a, i*lw, lw) == uval(b, i*lw, lw);
        else if (sg) t = sval(a, i*lw, lw) > sval(b, i*lw, lw);
        else t = uval(a, i*lw, lw) > uval(b, i*lw, lw);
        if (t) res |= 64'(mask) << (i*lw);
      end
      11, 12: for (int k = 0; k < 4; k++) begin
        longint p = sg ? sval(a, 16*k, 16) * sval(b, 16*k, 16)
                       : uval(a, 16*k, 16) * uval(b, 16*k, 16);
        if (op == 11) res |= 64'(p & 64'hFFFF) << (16*k);
        else res = res + (64'(p & 64'hFFFF_FFFF) << (32*(k/2)));
      end
      13: if (sz != 0) begin
        int     dw = lw / 2;
        longint dmask = (longint'(1) << dw) - 1;
        for (int o = 0; o < 2; o++) begin
          for (int i = 0; i < nl; i++) begin
            longint v;
            if (sg) begin
              v = sval(o == 0 ? a : b, i*lw, lw);
              if (v > (dmask >> 1)) v = dmask >> 1;
              if (v < -(dmask >> 1) - 1) v = -(dmask >> 1) - 1;
            end else begin
              v = uval(o == 0 ? a : b, i*lw, lw);
              if (v > dmask) v = dmask;
            end
            res |= 64'(v & dmask) << (o*32 + i*dw);
          end
        end
      end
      default: res = '0;
    endcase
    // multiply-add pair sums wrap per 32-bit half
    if (op == 12) begin
      longint lo = 0, hi = 0;
      for (int k = 0; k < 4; k++) begin
        longint p = sg ? sval(a, 16*k, 16) * sval(b, 16*k, 16)
                       : uval(a, 16*k, 16) * uval(b, 16*k, 16);
        if (k < 2) lo += p; else hi += p;
      end
      res = {32'(hi), 32'(lo)};
    end
    return res;
  endfunction

  function automatic string req_of(int op, bit sg, bit sat);
    if (op <= 1) return sat ? (sg ? "R4" : "R3") : "R2";
    if (op <= 4) return "R5";
    if (op <= 8) return "R6";
    if (op <= 10) return "R7";
    if (op == 11) return "R8";
    if (op == 12) return "R9";
    if (op == 13) return "R10";
    return "R11";
  endfunction

  task automatic check(string tag, logic [63:0] got, logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h (op=%0d sz=%0d sg=%0d sat=%0d sh=%0d)",
               tag, got, exp, opcode, lane_sz, is_signed, sat_en, shamt);
    end
  endtask

  task automatic run_op(logic [63:0] a, logic [63:0] b, int op, int sz,
                        bit sg, bit sat, int sh);
    @(negedge clk);
    op_a = a; op_b = b; opcode = 4'(op); lane_sz = 2'(sz);
    is_signed = sg; sat_en = sat; shamt = 7'(sh);
    @(negedge clk);
    check(req_of(op, sg, sat), result, ref_model(a, b, op, sz, sg, sat, sh));
  endtask

  initial begin : watchdog
    #(CLK_NS * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad);
      $finish;
    end
  end

  initial begin : main
    logic [63:0] held;
    void'($urandom(32'h5EED_0A1C));
    // R1: reset clears the register even with live inputs
    op_a = 64'h1234_5678_9ABC_DEF0; op_b = 64'h1; opcode = 4'd7;
    repeat (3) @(negedge clk);
    check("R1", result, 64'h0);
    rst = 1'b0;
    // R1: latency - new inputs do not reach result before the edge
    run_op(64'hF0F0, 64'h0F0F, 7, 0, 0, 0, 0);
    held = result;
    op_a = 64'hAAAA; op_b = 64'h5555; opcode = 4'd8;
    #1;
    check("R1", result, held);
    @(negedge clk);
    check("R1", result, 64'hFFFF);

    // R2: carries and borrows held at lane boundaries
    run_op(64'h0000_0000_0000_00FF, 64'h1, 0, 0, 0, 0, 0);
    check("R2", result, 64'h0);
    run_op(64'h0, 64'h1, 1, 1, 0, 0, 0);
    check("R2", result, 64'h0000_0000_0000_FFFF);
    run_op(64'hFFFF_FFFF_0000_0000, 64'h0000_0001_0000_0001, 0, 3, 0, 0, 0);
    // R3: unsigned saturation
    run_op(64'hFFF0_0000_0000_0010, 64'h0020_0000_0000_0020, 0, 1, 0, 1, 0);
    check("R3", result, 64'hFFFF_0000_0000_0030);
    run_op(64'h0005, 64'h0009, 1, 0, 0, 1, 0);
    // R4: signed saturation both sides
    run_op(64'h7F, 64'h01, 0, 0, 1, 1, 0);
    check("R4", result, 64'h7F);
    run_op(64'h8000_0000, 64'h1, 1, 2, 1, 1, 0);
    check("R4", result, 64'h8000_0000);
    // R5: shifts, counts at and beyond lane width
    run_op(64'h8000_8000_0001_7FFF, 0, 4, 1, 0, 0, 20);
    check("R5", result, 64'hFFFF_FFFF_0000_0000);
    run_op(64'hFFFF_FFFF_FFFF_FFFF, 0, 3, 2, 0, 0, 40);
    run_op(64'h8181_8181_8181_8181, 0, 2, 0, 0, 0, 3);
    run_op(64'h8181_8181_8181_8181, 0, 4, 0, 0, 0, 7);
    // R6: and-not
    run_op(64'hFF00_FF00_FF00_FF00, 64'hFFFF_0000_FFFF_0000, 6, 0, 0, 0, 0);
    check("R6", result, 64'h00FF_0000_00FF_0000);
    // R7: signed vs unsigned greater-than
    run_op(64'hFF, 64'h01, 10, 0, 1, 0, 0);
    run_op(64'hFF, 64'h01, 10, 0, 0, 0, 0);
    check("R7", result[7:0], 8'hFF);
    run_op(64'h1234_0000_1234_5678, 64'h1234_0000_1234_5678, 9, 1, 0, 0, 0);
    // R8, R9: multiply and multiply-add
    run_op(64'hFFFF, 64'h0002, 11, 2, 1, 0, 0);
    check("R8", result, 64'hFFFE);
    run_op(64'h8000_8000_FFFF_0003, 64'h8000_8000_0002_0004, 12, 0, 1, 0, 0);
    run_op(64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 12, 0, 0, 0, 0);
    // R10: pack clamping and placement
    run_op(64'h0180_FF00_0005_FF80, 64'h0001_0002_0003_0004, 13, 1, 1, 0, 0);
    check("R10", result, 64'h0102_0304_7F80_0580);
    run_op(64'h0180_FF00_0005_FF80, 64'h0001_0002_0003_0004, 13, 1, 0, 0, 0);
    run_op(64'h0001_0000_FFFF_8000, 64'h7FFF_FFFF_0000_1234, 13, 2, 1, 0, 0);
    run_op(64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 13, 0, 1, 0, 0);
    check("R10", result, 64'h0);
    // R11: unused opcodes
    run_op(64'hFFFF, 64'hFFFF, 14, 0, 0, 0, 0);
    run_op(64'hFFFF, 64'hFFFF, 15, 2, 1, 1, 5);

    // seeded random operations
    for (int n = 0; n < 800; n++) begin
      logic [63:0] ra = {$urandom, $urandom};
      logic [63:0] rb = ($urandom_range(0, 7) == 0) ? ra : {$urandom, $urandom};
      run_op(ra, rb, int'($urandom_range(0, 15)), int'($urandom_range(0, 3)),
             bit'($urandom_range(0, 1)), bit'($urandom_range(0, 1)),
             int'($urandom_range(0, 127)));
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule